// File: doc/BRIEF.md
# Cached Store Backup Buffer

This block keeps an ordered record of allocating stores that target cacheable memory. Each record is a 32-bit address and a 32-bit data word. It lets a cache model undo or replay those stores. A store presented with its cacheable qualifier set is appended behind all earlier records. A store without the qualifier leaves the buffer untouched.

A discard strobe throws away every record at once. An invalidate request names an address, and the buffer looks for the oldest record whose address lies in the same 32-byte line. If it finds one, that record's address and data leave through a single-beat write-back port with a valid/ready handshake. The record is removed, and the younger records close the gap in the same cycle, keeping their relative order. While a write-back waits for ready, the buffer accepts no other operation. The buffer depth is a parameter. A cacheable store that arrives when the buffer is full is dropped and flagged.

Top module: `store_backup_buf`

## Requirements
- R1: After reset the buffer is empty, `wbValid` is 0 and `overflow` is 0.
- R2: A store with `stValid` and `stCacheable` both high is appended at the tail. A store with `stCacheable` low changes nothing.
- R3: An invalidate compares addresses on bits [31:5] only. The oldest matching record is the one written back, with `wbAddr` and `wbData` equal to its stored address and data.
- R4: After a removal, the remaining records keep their insertion order.
- R5: An invalidate that matches no record raises no write-back and leaves the contents unchanged.
- R6: While `wbValid` is high and `wbReady` is low, `wbAddr` and `wbData` hold steady. Stores, discards and invalidates presented in that time are ignored. `wbValid` falls after the edge where `wbReady` is sampled high.
- R7: A discard empties the buffer, and later invalidates find nothing.
- R8: A cacheable store into a full buffer is dropped. `overflow` is high for exactly the cycle after that edge. The count never exceeds the depth.
- R9: When several requests arrive in the same cycle, discard wins over invalidate, and invalidate wins over store. A store that loses is dropped.
- R10: `wbValid` rises in the cycle right after the edge that accepts a matching invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| stValid | input | 1 | Store record present |
| stCacheable | input | 1 | Store target is cacheable |
| stAddr | input | 32 | Store address |
| stData | input | 32 | Store data |
| discard | input | 1 | Drop all records |
| invValid | input | 1 | Line invalidate request |
| invAddr | input | 32 | Address naming the line to invalidate |
| wbValid | output | 1 | Write-back beat pending |
| wbAddr | output | 32 | Write-back address |
| wbData | output | 32 | Write-back data |
| wbReady | input | 1 | Sink accepts the write-back beat |
| overflow | output | 1 | Previous cycle dropped a store because the buffer was full |

## Verification
The assertions assume that reset is held low for at least one clock edge before any request. They also assume that `wbReady` only matters while `wbValid` is high, so that a pending beat is the only thing that can freeze the buffer.

The bench drives every request at the falling edge and holds it for exactly one cycle. It raises `wbReady` only after it has seen `wbValid`. It deliberately presents stores and discards while a beat is pending, to exercise the ignore rule. Addresses are drawn from a handful of lines with random offsets inside each line, so that multiple matches and partial-address aliasing occur often.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic append;
    logic remove;
    logic clear;
  } bufCmd_t;
endpackage

// File: rtl/sbb_datapath.sv
module sbb_datapath
  import sbb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufCmd_t       cmd,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic [AW-1:0] invAddr,
  output logic          lineHit,
  output logic          full,
  output logic [CW-1:0] entryCount,
  output logic [AW-1:0] wbAddr,
  output logic [DW-1:0] wbData
);
  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [CW-1:0] countQ;
  logic [DEPTH-1:0] matchVec;
  logic [IW-1:0] hitIdx;
  logic [AW-1:0] wbAddrQ;
  logic [DW-1:0] wbDataQ;

  assign full       = (countQ == CW'(DEPTH));
  assign entryCount = countQ;
  assign wbAddr     = wbAddrQ;
  assign wbData     = wbDataQ;

  // line compare per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    localparam logic [CW-1:0] SLOT = CW'(i);
    assign matchVec[i] = (SLOT < countQ) &&
                         (addrQ[i][AW-1:LINE_BITS] == invAddr[AW-1:LINE_BITS]);
  end

  // oldest match has lowest index
  always_comb begin
    lineHit = 1'b0;
    hitIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        lineHit = 1'b1;
        hitIdx  = IW'(i);
      end
    end
  end

  // per-slot shift/append with compaction on removal
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [CW-1:0] SLOT  = CW'(i);
    localparam logic [IW-1:0] SLOTI = IW'(i);
    logic shiftIn;
    logic loadNew;
    assign shiftIn = cmd.remove && (SLOTI >= hitIdx);
    assign loadNew = cmd.append && (countQ == SLOT);
    if (i < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (shiftIn) begin
          addrQ[i] <= addrQ[i+1];
          dataQ[i] <= dataQ[i+1];
        end else if (loadNew) begin
          addrQ[i] <= stAddr;
          dataQ[i] <= stData;
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (loadNew && !shiftIn) begin
          addrQ[i] <= stAddr;
          dataQ[i] <= stData;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (cmd.clear) begin
      countQ <= '0;
    end else if (cmd.remove) begin
      countQ <= countQ - 1'b1;
    end else if (cmd.append) begin
      countQ <= countQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbAddrQ <= '0;
      wbDataQ <= '0;
    end else if (cmd.remove) begin
      wbAddrQ <= addrQ[hitIdx];
      wbDataQ <= dataQ[hitIdx];
    end
  end
endmodule

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
  import sbb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    stValid,
  input  logic    stCacheable,
  input  logic    discard,
  input  logic    invValid,
  input  logic    lineHit,
  input  logic    full,
  input  logic    wbReady,
  output bufCmd_t cmd,
  output logic    wbValid,
  output logic    overflow
);
  logic wbValidQ;
  logic overflowQ;
  logic idle;
  logic storeReq;

  assign idle     = !wbValidQ;
  assign storeReq = idle && !discard && !invValid && stValid && stCacheable;

  always_comb begin
    cmd        = '0;
    cmd.clear  = idle && discard;
    cmd.remove = idle && !discard && invValid && lineHit;
    cmd.append = storeReq && !full;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValidQ  <= 1'b0;
      overflowQ <= 1'b0;
    end else begin
      overflowQ <= storeReq && full;
      if (cmd.remove) begin
        wbValidQ <= 1'b1;
      end else if (wbValidQ && wbReady) begin
        wbValidQ <= 1'b0;
      end
    end
  end

  assign wbValid  = wbValidQ;
  assign overflow = overflowQ;
endmodule

// File: rtl/store_backup_buf.sv
module store_backup_buf
  import sbb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LINE_BITS = 5,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stValid,
  input  logic        stCacheable,
  input  logic [31:0] stAddr,
  input  logic [31:0] stData,
  input  logic        discard,
  input  logic        invValid,
  input  logic [31:0] invAddr,
  output logic        wbValid,
  output logic [31:0] wbAddr,
  output logic [31:0] wbData,
  input  logic        wbReady,
  output logic        overflow
);
  bufCmd_t       cmd;
  logic          lineHit;
  logic          full;
  logic [CW-1:0] entryCount;

  sbb_ctrl uCtrl (
    .clk, .rstN, .stValid, .stCacheable, .discard, .invValid,
    .lineHit, .full, .wbReady, .cmd, .wbValid, .overflow
  );

  sbb_datapath #(
    .DEPTH(DEPTH), .AW(32), .DW(32), .LINE_BITS(LINE_BITS)
  ) uDp (
    .clk, .rstN, .cmd, .stAddr, .stData, .invAddr,
    .lineHit, .full, .entryCount, .wbAddr, .wbData
  );
endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wbValid,
  input logic          wbReady,
  input logic [31:0]   wbAddr,
  input logic [31:0]   wbData,
  input logic          overflow,
  input logic          discard,
  input logic          invValid,
  input logic          lineHit,
  input logic [CW-1:0] entryCount
);
  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !wbReady |=> wbValid && $stable(wbAddr) && $stable(wbData));

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> entryCount == $past(entryCount));

  // R7
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    discard && !wbValid |=> entryCount == 0);

  // R8
  overflow_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> $past(entryCount) == CW'(DEPTH));

  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= CW'(DEPTH));

  // R10
  wb_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wbValid) |-> entryCount == $past(entryCount) - 1'b1);

  // R5
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    invValid && !wbValid && !discard && !lineHit |=> !wbValid);
endmodule

bind store_backup_buf sbb_checker #(.DEPTH(DEPTH)) uChk (
  .clk, .rstN, .wbValid, .wbReady, .wbAddr, .wbData, .overflow,
  .discard, .invValid, .lineHit, .entryCount
);

// File: tb/sim_store_backup_buf.sv
module sim_store_backup_buf;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        stValid = 1'b0, stCacheable = 1'b0, discard = 1'b0, invValid = 1'b0, wbReady = 1'b0;
  logic [31:0] stAddr = '0, stData = '0, invAddr = '0;
  logic        wbValid, overflow;
  logic [31:0] wbAddr, wbData;

  store_backup_buf #(.DEPTH(DEPTH)) u0 (
    .clk, .rstN, .stValid, .stCacheable, .stAddr, .stData, .discard,
    .invValid, .invAddr, .wbValid, .wbAddr, .wbData, .wbReady, .overflow
  );

  int vecs = 0;
  int errs = 0;
  logic [31:0] mA[$];
  logic [31:0] mD[$];
  logic [31:0] lfsr = 32'hACE1_0001;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic logic [31:0] pickAddr(input int lines);
    logic [31:0] r;
    r = rnd();
    return 32'h0000_4000 + ((r[15:8] % lines) << 5) + {27'd0, r[4:0]};
  endfunction

  // R2 R8: store, overflow checked in the cycle after the edge
  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic c);
    logic expOv;
    @(negedge clk);
    stValid = 1'b1; stCacheable = c; stAddr = a; stData = d;
    @(negedge clk);
    stValid = 1'b0;
    expOv = c && (mA.size() == DEPTH);
    chk("R8 overflow pulse", {31'd0, overflow}, {31'd0, expOv});
    chk("R2 store raises no wb", {31'd0, wbValid}, 32'd0);
    if (c && mA.size() < DEPTH) begin
      mA.push_back(a);
      mD.push_back(d);
    end
  endtask

  task automatic dropAll();
    @(negedge clk);
    discard = 1'b1;
    @(negedge clk);
    discard = 1'b0;
    mA.delete(); mD.delete();
    chk("R7 discard raises no wb", {31'd0, wbValid}, 32'd0);
  endtask

  // R3 R5 R6 R10
  task automatic inval(input logic [31:0] a, input int holdCycles);
    int idx;
    logic [31:0] ea, ed;
    idx = -1;
    foreach (mA[k]) if (idx < 0 && mA[k][31:5] == a[31:5]) idx = k;
    @(negedge clk);
    invValid = 1'b1; invAddr = a;
    @(negedge clk);
    invValid = 1'b0;
    if (idx < 0) begin
      chk("R5 no match no wb", {31'd0, wbValid}, 32'd0);
    end else begin
      ea = mA[idx]; ed = mD[idx];
      mA.delete(idx); mD.delete(idx);
      chk("R10 wb valid next cycle", {31'd0, wbValid}, 32'd1);
      chk("R3 wb address", wbAddr, ea);
      chk("R3 wb data", wbData, ed);
      for (int h = 0; h < holdCycles; h++) begin
        // these must be ignored while the beat is pending
        stValid = 1'b1; stCacheable = 1'b1; stAddr = ea; stData = ~ed;
        discard = h[0];
        @(negedge clk);
        stValid = 1'b0; discard = 1'b0;
        chk("R6 wb held", {31'd0, wbValid}, 32'd1);
        chk("R6 addr stable", wbAddr, ea);
        chk("R6 data stable", wbData, ed);
      end
      wbReady = 1'b1;
      @(negedge clk);
      wbReady = 1'b0;
      chk("R6 wb drops after ready", {31'd0, wbValid}, 32'd0);
    end
  endtask

  // R4: drain oldest-first and compare order, then confirm empty
  task automatic drain();
    while (mA.size() > 0) inval(mA[0], 0);
    inval(32'h0000_4000, 0);
    inval(32'h0000_4060, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vecs, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wbValid", {31'd0, wbValid}, 32'd0);
    chk("R1 reset overflow", {31'd0, overflow}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    inval(32'h0000_4000, 0);  // R1 empty after reset

    // R2: mixed cacheable/non-cacheable
    store(32'h0000_4004, 32'h1111_0001, 1'b1);
    store(32'h0000_4008, 32'h2222_0002, 1'b0);
    store(32'h0000_4024, 32'h3333_0003, 1'b1);
    store(32'h0000_400C, 32'h4444_0004, 1'b1);
    inval(32'h0000_401F, 1);  // oldest of line 0x4000
    drain();

    // R8: fill and overflow
    for (int i = 0; i < DEPTH + 2; i++) store(32'h0000_4000 + i * 4, 32'hA000_0000 + i, 1'b1);
    store(32'h0000_4100, 32'hDEAD_BEEF, 1'b0);
    drain();

    // R7: discard then nothing left
    store(32'h0000_4010, 32'h5, 1'b1);
    store(32'h0000_4030, 32'h6, 1'b1);
    dropAll();
    inval(32'h0000_4010, 0);
    inval(32'h0000_4030, 0);

    // R9: discard + invalidate + store together
    store(32'h0000_4040, 32'h77, 1'b1);
    @(negedge clk);
    discard = 1'b1; invValid = 1'b1; invAddr = 32'h0000_4040;
    stValid = 1'b1; stCacheable = 1'b1; stAddr = 32'h0000_4044; stData = 32'h88;
    @(negedge clk);
    discard = 1'b0; invValid = 1'b0; stValid = 1'b0;
    mA.delete(); mD.delete();
    chk("R9 discard beats invalidate", {31'd0, wbValid}, 32'd0);
    drain();
    // R9: invalidate (match) + store: store dropped
    store(32'h0000_4040, 32'h99, 1'b1);
    @(negedge clk);
    invValid = 1'b1; invAddr = 32'h0000_4050;
    stValid = 1'b1; stCacheable = 1'b1; stAddr = 32'h0000_4060; stData = 32'hAA;
    @(negedge clk);
    invValid = 1'b0; stValid = 1'b0;
    chk("R9 invalidate wins wb", {31'd0, wbValid}, 32'd1);
    chk("R9 invalidate wins addr", wbAddr, 32'h0000_4040);
    wbReady = 1'b1;
    @(negedge clk);
    wbReady = 1'b0;
    mA.delete(); mD.delete();
    // R9: invalidate (no match) + store: store dropped
    @(negedge clk);
    invValid = 1'b1; invAddr = 32'h0000_4200;
    stValid = 1'b1; stCacheable = 1'b1; stAddr = 32'h0000_4000; stData = 32'hBB;
    @(negedge clk);
    invValid = 1'b0; stValid = 1'b0;
    drain();

    // R3 R4 R5 R6 R10 sweep over few lines with random offsets
    for (int round = 0; round < 300; round++) begin
      logic [31:0] rr;
      rr = rnd();
      for (int n = 0; n < int'(rr[2:0] % (DEPTH + 2)); n++)
        store(pickAddr(3), rnd(), rnd() % 4 != 0);
      for (int n = 0; n < 3; n++) inval(pickAddr(5), int'(rnd() % 3));
      if (rr[20:18] == 0) dropAll();
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule